// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that finishes one instruction in every clock cycle. It fetches a word from its internal instruction store at the current program counter and decodes it. It then reads up to two registers, computes through an ALU, and optionally touches its internal data store. The result is written back at the next rising edge, when the program counter also moves on. The core runs seven instructions: register add, register subtract, OR with an immediate, word load, word store, branch when two registers are equal, and an absolute jump.

The instruction store and the data store are small word arrays held inside the core. A testbench or an enclosing test harness fills the instruction store before reset is released. Outside the core, progress is visible only through debug taps. These taps carry the program counter of the instruction now executing and the register write that instruction will commit at the coming clock edge.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high (synchronous, active high), the next clock edge sets the program counter to 0. No register or memory write takes place, and `dbg_wr_en` stays low.
- R2: An instruction with opcode bits [31:26] = 000000 is in register format, with rs in [25:21], rt in [20:16] and rd in [15:11]. Funct [5:0] = 100000 writes R[rs] + R[rt] to rd, and funct 100010 writes R[rs] - R[rt] to rd, both modulo 2^32.
- R3: Opcode 001101 writes R[rs] OR the zero-extended imm16 [15:0] to rt. Bit 15 of the immediate never reaches bits [31:16].
- R4: Opcode 100011 loads the data word at R[rs] + sign-extended imm16 into rt. Opcode 101011 stores R[rt] at that address and writes no register. A negative offset moves the address downward.
- R5: Both memories are word-addressed by address bits [W+1:2], where W is log2 of the depth. Address bits [1:0] have no effect, so byte address 11 selects the same word as byte address 8.
- R6: Opcode 000100 compares R[rs] with R[rt]. When they are equal, the next PC is PC + 4 + (sign-extended imm16 × 4). Otherwise the next PC is PC + 4. It writes no register and no memory.
- R7: Opcode 000010 sets the next PC to {(PC+4)[31:28], instr[25:0], 00} and writes nothing.
- R8: Register 0 always reads as zero. A write aimed at register 0 is discarded, and `dbg_wr_en` stays low for it.
- R9: Operands are read before the write at the end of the cycle. An instruction that reads and writes the same register uses the old value, and the next instruction sees the new one.
- R10: Any opcode outside the seven above, and any register-format funct other than add or subtract, acts as a no-op. It writes nothing and advances the PC by 4.
- R11: Every instruction other than a taken branch or a jump advances the PC by exactly 4, one instruction per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Byte address of the instruction executing this cycle |
| dbg_wr_en | output | 1 | High when this instruction commits a register write at the next edge |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_val | output | 32 | Value of that write |

## Verification
The ports show only the PC and the register-write tap. A store, the discarding of a write to register 0, and a branch outcome therefore have to be made visible through later instructions. The program loads back stored words, once with a negative offset and once with unaligned low address bits. It adds register 0 into a fresh register after aiming a write at it, and it places poison writes in the slots that a taken branch or a jump must skip. The test finishes in a branch-to-self, so the PC trace must hold steady at one address with no writes.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN      = 32;
    localparam int REG_COUNT = 32;
    localparam int RIDX_W    = $clog2(REG_COUNT);

    localparam logic [5:0] OPC_REG  = 6'b000000;
    localparam logic [5:0] OPC_ORI  = 6'b001101;
    localparam logic [5:0] OPC_LOAD = 6'b100011;
    localparam logic [5:0] OPC_STOR = 6'b101011;
    localparam logic [5:0] OPC_BEQ  = 6'b000100;
    localparam logic [5:0] OPC_JMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    typedef enum logic [1:0] {
        NEXT_SEQ = 2'd0,
        NEXT_BEQ = 2'd1,
        NEXT_JMP = 2'd2
    } next_sel_e;

    typedef struct packed {
        logic      dst_is_rd;
        logic      opb_is_imm;
        logic      wb_from_mem;
        logic      reg_wr;
        logic      mem_wr;
        logic      imm_signed;
        alu_op_e   alu;
        next_sel_e next;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        dst_is_rd: 1'b0, opb_is_imm: 1'b0, wb_from_mem: 1'b0,
        reg_wr: 1'b0, mem_wr: 1'b0, imm_signed: 1'b0,
        alu: ALU_ADD, next: NEXT_SEQ
    };

    typedef struct packed {
        logic [5:0]        opc;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        fn;
    } instr_t;

    function automatic logic [XLEN-1:0] widen16(input logic [15:0] v, input logic signed_ext);
        return {{(XLEN-16){signed_ext & v[15]}}, v};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [5:0] fn,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = CTRL_IDLE;
        unique case (opc)
            OPC_REG: begin
                if (fn == FN_ADD || fn == FN_SUB) begin
                    ctrl.dst_is_rd = 1'b1;
                    ctrl.reg_wr    = 1'b1;
                    ctrl.alu       = (fn == FN_SUB) ? ALU_SUB : ALU_ADD;
                end
            end
            OPC_ORI: begin
                ctrl.opb_is_imm = 1'b1;
                ctrl.reg_wr     = 1'b1;
                ctrl.alu        = ALU_OR;
            end
            OPC_LOAD: begin
                ctrl.opb_is_imm  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_wr      = 1'b1;
                ctrl.imm_signed  = 1'b1;
            end
            OPC_STOR: begin
                ctrl.opb_is_imm = 1'b1;
                ctrl.mem_wr     = 1'b1;
                ctrl.imm_signed = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.alu  = ALU_SUB;
                ctrl.next = NEXT_BEQ;
            end
            OPC_JMP: begin
                ctrl.next = NEXT_JMP;
            end
            default: ctrl = CTRL_IDLE;
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int DEPTH = REG_COUNT,
    parameter int WIDTH = XLEN,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_val,
    input  logic [AW-1:0]    rd_idx_a,
    input  logic [AW-1:0]    rd_idx_b,
    output logic [WIDTH-1:0] rd_val_a,
    output logic [WIDTH-1:0] rd_val_b
);
    logic [WIDTH-1:0] cells [DEPTH];

    // Entry 0 is a constant zero; only entries 1..DEPTH-1 hold state.
    assign cells[0] = '0;

    for (genvar g = 1; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == AW'(g)) begin
                cells[g] <= wr_val;
            end
        end
    end

    assign rd_val_a = cells[rd_idx_a];
    assign rd_val_b = cells[rd_idx_b];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int WIDTH = XLEN
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             is_zero
);
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    assign is_zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   dbg_pc,
    output logic              dbg_wr_en,
    output logic [RIDX_W-1:0] dbg_wr_idx,
    output logic [XLEN-1:0]   dbg_wr_val
);
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    // Instruction store starts as all-zero words, which decode as no-ops.
    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) begin
            imem[i] = '0;
        end
    end

    logic [XLEN-1:0]   pc;
    logic [XLEN-1:0]   pc_plus4;
    logic [XLEN-1:0]   pc_branch;
    logic [XLEN-1:0]   pc_jump;
    logic [XLEN-1:0]   pc_next;
    instr_t            instr;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   opa;
    logic [XLEN-1:0]   opb_reg;
    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   alu_y;
    logic              alu_zero;
    logic [XLEN-1:0]   mem_rdata;
    logic [XLEN-1:0]   wb_val;
    logic [RIDX_W-1:0] wb_idx;
    logic              rf_we;
    logic              dm_we;
    logic [15:0]       imm16;
    logic [25:0]       jidx;

    // Fetch
    assign instr = instr_t'(imem[pc[IAW+1:2]]);
    assign imm16 = {instr.rd, instr.shamt, instr.fn};
    assign jidx  = {instr.rs, instr.rt, imm16};

    sc_decode u_dec (
        .opc  (instr.opc),
        .fn   (instr.fn),
        .ctrl (ctrl)
    );

    assign rf_we = ctrl.reg_wr & ~rst;
    assign dm_we = ctrl.mem_wr & ~rst;
    assign wb_idx = ctrl.dst_is_rd ? instr.rd : instr.rt;

    sc_regfile #(.DEPTH(REG_COUNT), .WIDTH(XLEN)) u_rf (
        .clk      (clk),
        .wr_en    (rf_we),
        .wr_idx   (wb_idx),
        .wr_val   (wb_val),
        .rd_idx_a (instr.rs),
        .rd_idx_b (instr.rt),
        .rd_val_a (opa),
        .rd_val_b (opb_reg)
    );

    assign imm_ext = widen16(imm16, ctrl.imm_signed);

    sc_alu #(.WIDTH(XLEN)) u_alu (
        .op      (ctrl.alu),
        .a       (opa),
        .b       (ctrl.opb_is_imm ? imm_ext : opb_reg),
        .y       (alu_y),
        .is_zero (alu_zero)
    );

    // Data store: word-indexed, low two address bits dropped.
    assign mem_rdata = dmem[alu_y[DAW+1:2]];

    always_ff @(posedge clk) begin
        if (dm_we) begin
            dmem[alu_y[DAW+1:2]] <= opb_reg;
        end
    end

    assign wb_val = ctrl.wb_from_mem ? mem_rdata : alu_y;

    // Next-PC selection
    assign pc_plus4  = pc + XLEN'(4);
    assign pc_branch = pc_plus4 + {widen16(imm16, 1'b1)[XLEN-3:0], 2'b00};
    assign pc_jump   = {pc_plus4[XLEN-1:XLEN-4], jidx, 2'b00};

    always_comb begin
        unique case (ctrl.next)
            NEXT_BEQ: pc_next = alu_zero ? pc_branch : pc_plus4;
            NEXT_JMP: pc_next = pc_jump;
            default:  pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_next;
        end
    end

    // Debug taps
    assign dbg_pc     = pc;
    assign dbg_wr_en  = rf_we && (wb_idx != '0);
    assign dbg_wr_idx = wb_idx;
    assign dbg_wr_val = wb_val;

    logic unused_bits;
    assign unused_bits = ^{pc[1:0], pc[XLEN-1:IAW+2]};
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc,
    input logic              tap_we,
    input logic [RIDX_W-1:0] tap_idx,
    input logic [5:0]        opc,
    input next_sel_e         next,
    input logic              rf_we,
    input logic              dm_we
);
    // R1
    rst_pc_zero_chk: assert property (@(posedge clk) rst |=> (pc == '0));

    // R1
    rst_quiet_chk: assert property (@(posedge clk) rst |-> (!rf_we && !dm_we && !tap_we));

    // R8
    tap_r0_chk: assert property (@(posedge clk) disable iff (rst)
        tap_we |-> (tap_idx != '0));

    // R11
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (next == NEXT_SEQ) |=> (pc == $past(pc) + 32'd4));

    // R6
    beq_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BEQ) |-> (!rf_we && !dm_we));

    // R4
    store_only_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_STOR) |-> (dm_we && !rf_we));

    // R10
    unknown_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (opc != OPC_REG && opc != OPC_ORI && opc != OPC_LOAD &&
         opc != OPC_STOR && opc != OPC_BEQ && opc != OPC_JMP) |-> (!rf_we && !dm_we));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (dbg_pc),
    .tap_we  (dbg_wr_en),
    .tap_idx (dbg_wr_idx),
    .opc     (instr.opc),
    .next    (ctrl.next),
    .rf_we   (rf_we),
    .dm_we   (dm_we)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;
    import sc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dbg_pc;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_idx;
    logic [31:0] dbg_wr_val;

    always #4 clk = ~clk;

    sc_core u_sc_core (
        .clk        (clk),
        .rst        (rst),
        .dbg_pc     (dbg_pc),
        .dbg_wr_en  (dbg_wr_en),
        .dbg_wr_idx (dbg_wr_idx),
        .dbg_wr_val (dbg_wr_val)
    );

    typedef struct {
        logic [31:0] pc;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    logic mon_on   = 1'b0;
    logic done     = 1'b0;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic expect_step(input logic [31:0] pc, input logic we, input logic [4:0] idx,
                               input logic [31:0] val, input string tag);
        exp_t e;
        e.pc = pc; e.we = we; e.idx = idx; e.val = val; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic put(input int w, input logic [31:0] word);
        u_sc_core.imem[w] = word;
    endtask

    task automatic load_program();
        put(0,  enc_i(6'b001101, 5'd0, 5'd1, 16'h8001));   // ori r1
        put(1,  enc_i(6'b001101, 5'd0, 5'd2, 16'h0005));   // ori r2
        put(2,  enc_r(5'd1, 5'd2, 5'd3, 6'b100000));       // add r3
        put(3,  enc_r(5'd2, 5'd1, 5'd4, 6'b100010));       // sub r4
        put(4,  enc_i(6'b101011, 5'd0, 5'd3, 16'd8));      // sw r3 -> word 2
        put(5,  enc_i(6'b101011, 5'd0, 5'd4, 16'd4));      // sw r4 -> word 1
        put(6,  enc_i(6'b100011, 5'd0, 5'd5, 16'd8));      // lw r5
        put(7,  enc_i(6'b100011, 5'd2, 5'd6, 16'hFFFF));   // lw r6, -1(r2)
        put(8,  enc_i(6'b100011, 5'd0, 5'd7, 16'd11));     // lw r7, 11(r0)
        put(9,  enc_r(5'd1, 5'd2, 5'd0, 6'b100000));       // add r0
        put(10, enc_r(5'd0, 5'd1, 5'd8, 6'b100000));       // add r8 = r0 + r1
        put(11, enc_r(5'd1, 5'd1, 5'd1, 6'b100000));       // add r1 = r1 + r1
        put(12, enc_r(5'd1, 5'd0, 5'd9, 6'b100000));       // add r9 = r1
        put(13, enc_i(6'b000100, 5'd1, 5'd2, 16'd5));      // beq not taken
        put(14, enc_i(6'b000100, 5'd5, 5'd3, 16'd2));      // beq taken -> 17
        put(15, enc_i(6'b001101, 5'd0, 5'd10, 16'hDEAD));  // skipped
        put(16, enc_i(6'b001101, 5'd0, 5'd10, 16'hBEEF));  // skipped
        put(17, enc_i(6'b001101, 5'd0, 5'd10, 16'h00AA));
        put(18, 32'hFC21_0000);                            // unknown opcode 111111
        put(19, {6'b000010, 26'd21});                      // j -> 84
        put(20, enc_i(6'b001101, 5'd0, 5'd11, 16'h0BAD));  // skipped
        put(21, enc_i(6'b001101, 5'd0, 5'd11, 16'hFFFF));
        put(22, enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF));   // branch to self
    endtask

    task automatic plan_trace();
        expect_step(32'd0,  1, 5'd1,  32'h0000_8001, "R3");
        expect_step(32'd4,  1, 5'd2,  32'h0000_0005, "R11");
        expect_step(32'd8,  1, 5'd3,  32'h0000_8006, "R2 add");
        expect_step(32'd12, 1, 5'd4,  32'hFFFF_8004, "R2 sub");
        expect_step(32'd16, 0, 5'd0,  32'h0,         "R4 store");
        expect_step(32'd20, 0, 5'd0,  32'h0,         "R4 store");
        expect_step(32'd24, 1, 5'd5,  32'h0000_8006, "R4 load");
        expect_step(32'd28, 1, 5'd6,  32'hFFFF_8004, "R4 negative offset");
        expect_step(32'd32, 1, 5'd7,  32'h0000_8006, "R5 low bits");
        expect_step(32'd36, 0, 5'd0,  32'h0,         "R8 write to r0");
        expect_step(32'd40, 1, 5'd8,  32'h0000_8001, "R8 r0 reads zero");
        expect_step(32'd44, 1, 5'd1,  32'h0001_0002, "R9 old value");
        expect_step(32'd48, 1, 5'd9,  32'h0001_0002, "R9 new value");
        expect_step(32'd52, 0, 5'd0,  32'h0,         "R6 not taken");
        expect_step(32'd56, 0, 5'd0,  32'h0,         "R6 taken");
        expect_step(32'd68, 1, 5'd10, 32'h0000_00AA, "R6 target");
        expect_step(32'd72, 0, 5'd0,  32'h0,         "R10");
        expect_step(32'd76, 0, 5'd0,  32'h0,         "R7");
        expect_step(32'd84, 1, 5'd11, 32'h0000_FFFF, "R7 target R3");
        for (int k = 0; k < 3; k++) begin
            expect_step(32'd88, 0, 5'd0, 32'h0, "R6 backward");
        end
    endtask

    // Monitor: pops one expected step per executed instruction.
    always begin
        @(negedge clk);
        #2;
        if (mon_on && exp_q.size() > 0) begin
            exp_t e;
            logic bad;
            e = exp_q.pop_front();
            n_checks++;
            bad = (dbg_pc !== e.pc) || (dbg_wr_en !== e.we) ||
                  (e.we && ((dbg_wr_idx !== e.idx) || (dbg_wr_val !== e.val)));
            if (bad) begin
                n_errors++;
                $display("FAIL %s: got pc=%0d we=%0b r%0d=%h, expected pc=%0d we=%0b r%0d=%h",
                         e.tag, dbg_pc, dbg_wr_en, dbg_wr_idx, dbg_wr_val,
                         e.pc, e.we, e.idx, e.val);
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #1;
        load_program();
        plan_trace();
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        n_checks++;
        if (dbg_pc !== 32'd0 || dbg_wr_en !== 1'b0) begin
            n_errors++;
            $display("FAIL R1 reset: got pc=%0d we=%0b, expected pc=0 we=0", dbg_pc, dbg_wr_en);
        end
        @(negedge clk);
        rst    = 1'b0;
        mon_on = 1'b1;
        for (int c = 0; c < 200 && exp_q.size() > 0; c++) begin
            @(negedge clk);
        end
        #5;
        mon_on = 1'b0;
        if (exp_q.size() > 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL R11 trace incomplete: got %0d steps left, expected 0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end
endmodule